// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block (No FIFO)

This block is the processor-side register set of a classic single-byte serial port. A host performs byte reads and writes at eight offsets. The block holds the interrupt identification state and raises an interrupt request. It accepts received bytes and break markers from a line-side receiver. It hands every transmitted byte to a line-side sender as a one-cycle strobe. It also exports the baud divisor once software commits it.

The model has no holding register and no FIFO. Transmission counts as instantaneous, so the line status always reports the transmitter idle, and the modem status always reports the carrier, data-set-ready and clear-to-send inputs as active. A pacer outside the block can postpone the "transmitter ready" interrupt. It does this by raising `tx_defer` while the data byte is written. It later pulses `tx_pace` to deliver that interrupt.

Offsets: 0 data / divisor low, 1 interrupt enable / divisor high, 2 interrupt identification (read) / FIFO control (write, discarded), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Line control bit 7 selects the divisor latch.

Top module: `uart_regfile`

## Requirements
- R1: After reset the interrupt request is low, offset 2 reads 0x01, offset 5 reads 0x60, the divisor output is 1 and `rx_ready` is high.
- R2: While line control bit 7 is set, offsets 0 and 1 write and read the divisor low and high bytes, and a write to offset 0 produces no transmit strobe.
- R3: The divisor output changes only on a line-control write that clears bit 7 while bit 7 was set. The new value is the held high/low pair, and a pair of zero is ignored.
- R4: A write to offset 0 with bit 7 clear pulses `tx_valid` for one cycle, with the written byte on `tx_byte`, in the cycle after the write.
- R5: An accepted data byte sets line status bit 0 and loads the data register. If interrupt-enable bit 0 is set, it also sets identification bit 2 and clears identification bit 0. `rx_kind` 0 (and 3) means a data byte.
- R6: While line status bit 0 is set, `rx_ready` is low, and an offered byte is not accepted and changes nothing.
- R7: A read of offset 0 with bit 7 clear returns the held byte, then clears the held byte to 0 and clears line status bit 0. It always clears identification bit 2, and an identification value that becomes 0 is replaced by 0x01.
- R8: A read of offset 2 returns the current identification value, then clears its bit 1, and a value that becomes 0 is replaced by 0x01.
- R9: Writing interrupt enable with bit 1 set sets identification bit 1 and leaves bit 0 alone. With interrupt-enable bit 1 set, a data write with `tx_defer` low sets identification bit 1 and clears bit 0. A `tx_pace` pulse always sets identification bit 1 and clears bit 0.
- R10: `rx_kind` 1 (break start) sets line status bit 4, and `rx_kind` 2 (break end) clears it. Both load a data byte of 0 and otherwise act like a received byte.
- R11: Line status reads always have bits 5 and 6 set, and modem status reads 0xB0. Writes to offsets 5 and 6, and writes to offset 2, change nothing that can be read.
- R12: `irq` is high exactly when identification bit 0 is clear.
- R13: Line control, modem control and scratch read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current read access, 0 otherwise |
| rx_valid | input | 1 | Receive event offered |
| rx_kind | input | 2 | 0 data, 1 break start, 2 break end, 3 data |
| rx_byte | input | 8 | Received data byte |
| rx_ready | output | 1 | Receive event will be accepted |
| tx_defer | input | 1 | Pacer postpones the ready interrupt of this data write |
| tx_pace | input | 1 | Pacer delivers a postponed ready interrupt |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| divisor | output | 16 | Committed baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the host makes at most one access per cycle. They also assume that a receive event counts as accepted only when `rx_valid` and `rx_ready` are both high in the same cycle. The bench drives at most one access per cycle and keeps each receive offer to a single cycle. It also offers bytes while the data register is full, to exercise the hold-off. The behavioural model in the bench applies the effects of a bus access before a pacer pulse, and a pacer pulse before a receive event. The stimulus keeps a read of offset 0 and an accepted byte in separate cycles, so that this ordering is never ambiguous.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 2 * DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IIR  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } reg_ofs_e;

    typedef enum logic [1:0] {
        RXK_DATA    = 2'd0,
        RXK_BRK_ON  = 2'd1,
        RXK_BRK_OFF = 2'd2,
        RXK_DATA_2  = 2'd3
    } rx_kind_e;

    // bit positions
    localparam int LCR_DIVSEL  = 7;
    localparam int IER_RX_EN   = 0;
    localparam int IER_TX_EN   = 1;
    localparam int ID_NONE     = 0;
    localparam int ID_TX       = 1;
    localparam int ID_RX       = 2;
    localparam int LS_RXFULL   = 0;
    localparam int LS_BREAK    = 4;
    localparam int LS_TXEMPTY  = 5;
    localparam int LS_SHIFTIDL = 6;

    localparam logic [DATA_W-1:0] MODEM_FIXED = 8'hB0;
    localparam logic [DATA_W-1:0] ID_IDLE     = 8'h01;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic rd_iir;
        logic wr_ier;
        logic wr_lcr;
        logic wr_mcr;
        logic wr_scr;
        logic wr_div_lo;
        logic wr_div_hi;
    } bus_evt_t;

    function automatic logic [DATA_W-1:0] id_settle(input logic [DATA_W-1:0] v);
        return (v == '0) ? ID_IDLE : v;
    endfunction

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
    import uart_regs_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              divsel,
    output bus_evt_t          evt
);
    reg_ofs_e ofs;
    logic     rd, wt;

    always_comb begin
        ofs = reg_ofs_e'(addr);
        rd  = sel && !wr;
        wt  = sel && wr;
        evt = '0;
        evt.rd_data   = rd && (ofs == OFS_DATA) && !divsel;
        evt.wr_data   = wt && (ofs == OFS_DATA) && !divsel;
        evt.wr_div_lo = wt && (ofs == OFS_DATA) && divsel;
        evt.wr_ier    = wt && (ofs == OFS_IER) && !divsel;
        evt.wr_div_hi = wt && (ofs == OFS_IER) && divsel;
        evt.rd_iir    = rd && (ofs == OFS_IIR);
        evt.wr_lcr    = wt && (ofs == OFS_LCR);
        evt.wr_mcr    = wt && (ofs == OFS_MCR);
        evt.wr_scr    = wt && (ofs == OFS_SCR);
    end
endmodule

// File: rtl/uart_iir_ctrl.sv
module uart_iir_ctrl
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_rx,
    input  logic              clr_tx,
    input  logic              flag_tx,
    input  logic              raise_tx,
    input  logic              raise_rx,
    output logic [DATA_W-1:0] iir
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = iir;
        if (clr_rx) nxt[ID_RX] = 1'b0;
        if (clr_tx) nxt[ID_TX] = 1'b0;
        if (clr_rx || clr_tx) nxt = id_settle(nxt);
        if (flag_tx) nxt[ID_TX] = 1'b1;
        if (raise_tx) begin
            nxt[ID_TX]   = 1'b1;
            nxt[ID_NONE] = 1'b0;
        end
        if (raise_rx) begin
            nxt[ID_RX]   = 1'b1;
            nxt[ID_NONE] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) iir <= ID_IDLE;
        else     iir <= nxt;
    end

    AST_ID_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        iir != '0); // R8

    AST_ID_TX_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr_tx && !flag_tx && !raise_tx |=> !iir[ID_TX]); // R8

    AST_ID_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $fell(iir[ID_NONE]) |-> $past(raise_tx || raise_rx)); // R9

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  rx_kind_e          kind,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              consume,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              brk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            brk  <= 1'b0;
        end else begin
            if (consume && full) begin
                data <= '0;
                full <= 1'b0;
            end
            if (take) begin
                full <= 1'b1;
                unique case (kind)
                    RXK_BRK_ON:  begin brk <= 1'b1; data <= '0; end
                    RXK_BRK_OFF: begin brk <= 1'b0; data <= '0; end
                    default:     data <= byte_in;
                endcase
            end
        end
    end

    AST_RX_LOADS: assert property (@(posedge clk) disable iff (rst)
        take && (kind == RXK_DATA) |=> full && (data == $past(byte_in))); // R5

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        full && !consume |=> full && $stable(data)); // R6

    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (rst)
        take && (kind == RXK_BRK_ON) |=> brk && (data == '0)); // R10

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [1:0]        rx_kind,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_ready,
    input  logic              tx_defer,
    input  logic              tx_pace,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq
);
    logic [DATA_W-1:0] ier, lcr, mcr, scr, dl, dh, iir, rxd;
    logic              rx_full, rx_brk, take;
    bus_evt_t          evt;
    logic [DATA_W-1:0] lsr_view;

    uart_bus_decode u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .divsel (lcr[LCR_DIVSEL]),
        .evt    (evt)
    );

    assign rx_ready = !rx_full;
    assign take     = rx_valid && rx_ready;

    uart_rx_hold u_rx (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .kind    (rx_kind_e'(rx_kind)),
        .byte_in (rx_byte),
        .consume (evt.rd_data),
        .data    (rxd),
        .full    (rx_full),
        .brk     (rx_brk)
    );

    uart_iir_ctrl u_iir (
        .clk      (clk),
        .rst      (rst),
        .clr_rx   (evt.rd_data),
        .clr_tx   (evt.rd_iir),
        .flag_tx  (evt.wr_ier && bus_wdata[IER_TX_EN]),
        .raise_tx ((evt.wr_data && ier[IER_TX_EN] && !tx_defer) || tx_pace),
        .raise_rx (take && ier[IER_RX_EN]),
        .iir      (iir)
    );

    assign irq = !iir[ID_NONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            ier      <= '0;
            lcr      <= '0;
            mcr      <= '0;
            scr      <= '0;
            dl       <= DIV_RESET[DATA_W-1:0];
            dh       <= DIV_RESET[DIV_W-1:DATA_W];
            divisor  <= DIV_RESET;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= evt.wr_data;
            if (evt.wr_data)   tx_byte <= bus_wdata;
            if (evt.wr_ier)    ier <= bus_wdata;
            if (evt.wr_mcr)    mcr <= bus_wdata;
            if (evt.wr_scr)    scr <= bus_wdata;
            if (evt.wr_div_lo) dl  <= bus_wdata;
            if (evt.wr_div_hi) dh  <= bus_wdata;
            if (evt.wr_lcr) begin
                lcr <= bus_wdata;
                if (lcr[LCR_DIVSEL] && !bus_wdata[LCR_DIVSEL] && ({dh, dl} != '0))
                    divisor <= {dh, dl};
            end
        end
    end

    always_comb begin
        lsr_view              = '0;
        lsr_view[LS_RXFULL]   = rx_full;
        lsr_view[LS_BREAK]    = rx_brk;
        lsr_view[LS_TXEMPTY]  = 1'b1;
        lsr_view[LS_SHIFTIDL] = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_ofs_e'(bus_addr))
                OFS_DATA: bus_rdata = lcr[LCR_DIVSEL] ? dl : rxd;
                OFS_IER:  bus_rdata = lcr[LCR_DIVSEL] ? dh : ier;
                OFS_IIR:  bus_rdata = iir;
                OFS_LCR:  bus_rdata = lcr;
                OFS_MCR:  bus_rdata = mcr;
                OFS_LSR:  bus_rdata = lsr_view;
                OFS_MSR:  bus_rdata = MODEM_FIXED;
                default:  bus_rdata = scr;
            endcase
        end
    end

    AST_DIV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(evt.wr_lcr && lcr[LCR_DIVSEL] && !bus_wdata[LCR_DIVSEL]) |=> $stable(divisor)); // R3

    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_sel && bus_wr && (bus_addr == OFS_DATA) && !lcr[LCR_DIVSEL])); // R4

    AST_REJECT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !rx_ready); // R6

endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       rx_valid = 0;
    logic [1:0] rx_kind = 0;
    logic [7:0] rx_byte = 0;
    logic       rx_ready, tx_defer = 0, tx_pace = 0, tx_valid, irq;
    logic [7:0] tx_byte;
    logic [15:0] divisor;

    int n_chk = 0, n_fail = 0;

    // reference model state
    int m_iir = 1, m_ier = 0, m_lcr = 0, m_mcr = 0, m_scr = 0;
    int m_dl = 1, m_dh = 0, m_div = 1, m_data = 0;
    bit m_full = 0, m_brk = 0, m_txv = 0;
    int m_txb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfile u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .tx_defer(tx_defer), .tx_pace(tx_pace),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .divisor(divisor), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int settle(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int model_read(input int a);
        bit dl_on = m_lcr[7];
        case (a)
            0: return dl_on ? m_dl : m_data;
            1: return dl_on ? m_dh : m_ier;
            2: return m_iir;
            3: return m_lcr;
            4: return m_mcr;
            5: return 32'h60 | (m_brk ? 32'h10 : 0) | (m_full ? 1 : 0);
            6: return 32'hB0;
            default: return m_scr;
        endcase
    endfunction

    task automatic model_step(input bit sel, input bit wr, input int a, input int wd,
                              input bit rxv, input int rxk, input int rxb,
                              input bit dfr, input bit pc);
        bit dl_on = m_lcr[7];
        bit take = rxv && !m_full;
        int ier_pre = m_ier;
        int v = m_iir;
        m_txv = 0;
        if (sel && wr) begin
            case (a)
                0: if (dl_on) m_dl = wd;
                   else begin
                       m_txv = 1; m_txb = wd;
                       if (ier_pre[1] && !dfr) v = (v | 2) & ~1;
                   end
                1: if (dl_on) m_dh = wd;
                   else begin m_ier = wd; if (wd[1]) v = v | 2; end
                3: begin
                       if (dl_on && !wd[7] && ((m_dh << 8) | m_dl) != 0)
                           m_div = (m_dh << 8) | m_dl;
                       m_lcr = wd;
                   end
                4: m_mcr = wd;
                7: m_scr = wd;
                default: ;
            endcase
        end
        if (sel && !wr) begin
            if (a == 0 && !dl_on) begin
                if (m_full) begin m_data = 0; m_full = 0; end
                v = settle(v & ~4);
            end
            if (a == 2) v = settle(v & ~2);
        end
        if (pc) v = (v | 2) & ~1;
        if (take) begin
            m_full = 1;
            if (rxk == 1) begin m_brk = 1; m_data = 0; end
            else if (rxk == 2) begin m_brk = 0; m_data = 0; end
            else m_data = rxb;
            if (ier_pre[0]) v = (v | 4) & ~1;
        end
        m_iir = v;
    endtask

    task automatic cyc(input bit sel, input bit wr, input int a, input int wd,
                       input bit rxv, input int rxk, input int rxb,
                       input bit dfr, input bit pc, input string tag);
        bus_sel = sel; bus_wr = wr; bus_addr = a[2:0]; bus_wdata = wd[7:0];
        rx_valid = rxv; rx_kind = rxk[1:0]; rx_byte = rxb[7:0];
        tx_defer = dfr; tx_pace = pc;
        #1;
        if (sel && !wr) chk({tag, " read data"}, bus_rdata, model_read(a));
        @(posedge clk);
        model_step(sel, wr, a, wd, rxv, rxk, rxb, dfr, pc);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; rx_valid = 0; tx_defer = 0; tx_pace = 0;
        chk("R12 irq", irq, (m_iir & 1) ? 0 : 1);
        chk("R6 rx_ready", rx_ready, m_full ? 0 : 1);
        chk("R4/R2 tx_valid", tx_valid, m_txv);
        if (m_txv) chk("R4 tx_byte", tx_byte, m_txb);
        chk("R3 divisor", divisor, m_div);
    endtask

    task automatic wr_reg(input int a, input int d, input string tag);
        cyc(1, 1, a, d, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic rd_reg(input int a, input string tag);
        cyc(1, 0, a, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic rx_ev(input int k, input int b);
        cyc(0, 0, 0, 0, 1, k, b, 0, 0, "R5");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 irq after reset", irq, 0);
        chk("R1 divisor after reset", divisor, 1);
        chk("R1 rx_ready after reset", rx_ready, 1);
        rd_reg(5, "R1 line status");
        rd_reg(2, "R1 ident");
        rd_reg(6, "R11 modem status");

        // R2 / R3 divisor latch
        wr_reg(3, 8'h83, "R2");
        wr_reg(0, 8'h0C, "R2");
        wr_reg(1, 8'h00, "R2");
        rd_reg(0, "R2 divisor low");
        rd_reg(1, "R2 divisor high");
        wr_reg(3, 8'h03, "R3");
        wr_reg(3, 8'h80, "R3");
        wr_reg(0, 8'h00, "R2");
        wr_reg(3, 8'h03, "R3 zero ignored");
        wr_reg(3, 8'h80, "R3");
        wr_reg(0, 8'h01, "R2");
        wr_reg(1, 8'h02, "R2");
        wr_reg(3, 8'h03, "R3");

        // R13 plain registers
        rd_reg(3, "R13 line control");
        wr_reg(4, 8'h0B, "R13");
        rd_reg(4, "R13 modem control");
        wr_reg(7, 8'h5A, "R13");
        rd_reg(7, "R13 scratch");

        // R11 ignored writes
        wr_reg(5, 8'hFF, "R11");
        rd_reg(5, "R11 line status");
        wr_reg(6, 8'h00, "R11");
        rd_reg(6, "R11 modem status");
        wr_reg(2, 8'hC7, "R11");
        rd_reg(2, "R11 ident after fifo write");

        // R5/R6/R7 receive without interrupt
        rx_ev(0, 8'h41);
        rd_reg(5, "R5 line status");
        rx_ev(0, 8'h42);
        rx_ev(0, 8'h43);
        rd_reg(0, "R6/R7 data");
        rd_reg(0, "R7 data after consume");
        rx_ev(0, 8'h42);
        rd_reg(0, "R7 data");

        // receive with interrupt
        wr_reg(1, 8'h01, "R5");
        rx_ev(3, 8'h55);
        rd_reg(2, "R5 ident");
        rd_reg(0, "R7 data");
        rd_reg(2, "R7 ident");

        // transmit interrupt paths
        wr_reg(1, 8'h03, "R9");
        rd_reg(2, "R9/R8 ident");
        wr_reg(0, 8'h33, "R4");
        rd_reg(2, "R8 ident");
        rd_reg(2, "R8 ident again");
        cyc(1, 1, 0, 8'h44, 0, 0, 0, 1, 0, "R9 deferred");
        rd_reg(2, "R9 ident deferred");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 pace");
        rd_reg(2, "R9 ident after pace");

        // combined sources
        rx_ev(0, 8'h66);
        wr_reg(0, 8'h77, "R4");
        rd_reg(2, "R8 combined ident");
        rd_reg(2, "R8 ident rx remains");
        rd_reg(0, "R7 data");
        rd_reg(2, "R7 ident cleared");

        // R10 break
        rx_ev(1, 8'hAA);
        rd_reg(5, "R10 line status break");
        rd_reg(0, "R10 data zero");
        rx_ev(2, 8'hBB);
        rd_reg(5, "R10 line status break end");
        rd_reg(0, "R10 data zero");
        rd_reg(5, "R10 line status idle");

        // R2 no transmit under divisor select
        wr_reg(3, 8'h80, "R2");
        wr_reg(0, 8'h09, "R2 no tx");
        rd_reg(0, "R2 divisor low");
        wr_reg(3, 8'h03, "R3");
        rd_reg(1, "R13 ier");
        repeat (2) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule